// File: doc/BRIEF.md
# Masked Vector Lane Writeback

This block builds the next value of a 512-bit vector destination register, held as eight 64-bit lanes, for a packed two-operand lane operation. An external arithmetic stage computes one result per lane. This block does three jobs around that stage. It presents the operand lanes that the arithmetic stage consumes, and for a memory-form EVEX operation it can replicate lane 0 of the second operand into every lane. It tells the arithmetic stage which rounding mode to use, including a one-operation override. It then merges the per-lane results with the old destination contents according to the encoding class, the active vector length and the write mask.

The operand and rounding outputs are combinational, so the arithmetic stage sees them in the same cycle as the inputs. The merged destination is captured on a valid strobe and appears one clock later, together with an output valid.

Top module: `vec_lane_wb`

## Requirements
- R1: After reset, `out_valid` is 0 and `new_dst` is all zero. A cycle with `in_valid` high makes `out_valid` high at the next clock edge. At that edge `new_dst` takes the merged value. A cycle with `in_valid` low makes `out_valid` low at the next edge and leaves `new_dst` unchanged.
- R2: When `enc_class` is 0 (legacy), lanes 0 and 1 take their results and lanes 2 to 7 keep their old destination value. In this class `vlen`, `mask`, `zero_ctl`, `mem_form` and `bcast_bit` have no effect on `new_dst`.
- R3: When `enc_class` is 1 (VEX), each lane below the active length takes its result whatever the mask says, and every other lane becomes zero. An `enc_class` of 3 behaves the same way.
- R4: `vlen` selects the active length. A value of 0 gives 2 lanes, 1 gives 4 lanes, and 2 or 3 gives 8 lanes.
- R5: When `enc_class` is 2 (EVEX), a lane below the active length whose mask bit is set takes its result. Mask bit n governs lane n.
- R6: In the EVEX class, a lane below the active length whose mask bit is clear becomes zero if `zero_ctl` is 1. If `zero_ctl` is 0, the lane keeps its old value.
- R7: In the EVEX class, lanes at or above the active length become zero, and the mask bits of those lanes have no effect.
- R8: `add_a` always equals `src1`. When the class is EVEX and both `mem_form` and `bcast_bit` are 1, every lane of `add_b` equals lane 0 of `src2`. In all other cases `add_b` equals `src2` lane by lane.
- R9: `rnd_ovr_valid` is 1 only when all of these hold: the class is EVEX, `mem_form` is 0, `bcast_bit` is 1, and the active length is 8 lanes. When it is 1, `rnd_mode` equals `rc_field`; otherwise `rnd_mode` equals `dflt_rnd`. The rounding codes are 0 nearest, 1 down, 2 up and 3 toward zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs are valid; capture the merged destination |
| enc_class | input | 2 | 0 legacy, 1 VEX, 2 EVEX, 3 treated as VEX |
| vlen | input | 2 | Active length code: 0 = 2 lanes, 1 = 4 lanes, 2 or 3 = 8 lanes |
| mem_form | input | 1 | Second operand comes from memory |
| bcast_bit | input | 1 | Broadcast (memory form) or rounding override (register form) |
| zero_ctl | input | 1 | Masked-off lanes are zeroed instead of merged |
| mask | input | 8 | Per-lane write mask, bit n for lane n |
| rc_field | input | 2 | Override rounding mode |
| dflt_rnd | input | 2 | Default rounding mode |
| old_dst | input | 512 | Current destination contents |
| src1 | input | 512 | First source operand |
| src2 | input | 512 | Second source operand |
| lane_result | input | 512 | Per-lane results from the arithmetic stage |
| add_a | output | 512 | First operand lanes for the arithmetic stage |
| add_b | output | 512 | Second operand lanes, possibly broadcast |
| rnd_ovr_valid | output | 1 | Rounding override is in force |
| rnd_mode | output | 2 | Rounding mode for the arithmetic stage |
| out_valid | output | 1 | `new_dst` holds a fresh result |
| new_dst | output | 512 | Merged destination value |

## Verification
A wrong per-lane select decode shows up as a single 64-bit lane of `new_dst` holding the old value, zero or the result when another source was expected. It is visible on the clock edge right after the strobe, so each vector is checked one cycle after it is applied. A wrong active-length decode corrupts a whole block of upper lanes at once, and a stuck capture register shows as `new_dst` changing on a cycle with no strobe, or failing to change on one with a strobe. Broadcast and rounding decode faults need no clock, so they are checked on `add_b`, `rnd_ovr_valid` and `rnd_mode` in the same cycle the inputs are driven.

// File: rtl/vlw_pkg.sv
`timescale 1ns/1ps
package vlw_pkg;

   typedef enum logic [1:0] {
      ENC_LEGACY = 2'd0,
      ENC_VEX    = 2'd1,
      ENC_EVEX   = 2'd2,
      ENC_RSVD   = 2'd3
   } enc_class_e;

   typedef enum logic [1:0] {
      RND_NEAREST = 2'd0,
      RND_DOWN    = 2'd1,
      RND_UP      = 2'd2,
      RND_ZERO    = 2'd3
   } rnd_mode_e;

   typedef enum logic [1:0] {
      LSEL_RESULT = 2'd0,
      LSEL_OLD    = 2'd1,
      LSEL_ZERO   = 2'd2
   } lane_sel_e;

endpackage

// File: rtl/vlw_lane_ctl.sv
`timescale 1ns/1ps
module vlw_lane_ctl
   import vlw_pkg::*;
#(
   parameter int LANES     = 8,
   parameter int MIN_LANES = 2,
   parameter int VLEN_W    = 2
) (
   input  logic [1:0]              enc_class,
   input  logic [VLEN_W-1:0]       vlen,
   input  logic                    zero_ctl,
   input  logic [LANES-1:0]        mask,
   output logic [LANES-1:0]        active,
   output logic [LANES-1:0][1:0]   lane_sel
);

   localparam int VLEN_TOP = $clog2(LANES / MIN_LANES);

   logic [31:0] kl;

   always_comb begin
      if (vlen >= VLEN_W'(VLEN_TOP)) kl = 32'(LANES);
      else                           kl = 32'(MIN_LANES) << vlen;
   end

   for (genvar n = 0; n < LANES; n++) begin : g_lane
      localparam logic [31:0] N_U       = 32'(n);
      localparam bit          IN_LEGACY = (n < MIN_LANES);
      lane_sel_e sel_c;

      assign active[n] = (kl > N_U);

      always_comb begin
         case (enc_class_e'(enc_class))
            ENC_LEGACY: sel_c = IN_LEGACY ? LSEL_RESULT : LSEL_OLD;
            ENC_EVEX: begin
               if (!active[n])    sel_c = LSEL_ZERO;
               else if (mask[n])  sel_c = LSEL_RESULT;
               else if (zero_ctl) sel_c = LSEL_ZERO;
               else               sel_c = LSEL_OLD;
            end
            default: sel_c = active[n] ? LSEL_RESULT : LSEL_ZERO;
         endcase
      end

      assign lane_sel[n] = sel_c;
   end

endmodule

// File: rtl/vlw_operand_sel.sv
`timescale 1ns/1ps
module vlw_operand_sel
   import vlw_pkg::*;
#(
   parameter int LANE_W = 64,
   parameter int LANES  = 8,
   localparam int DATA_W = LANE_W * LANES
) (
   input  logic [1:0]        enc_class,
   input  logic              mem_form,
   input  logic              bcast_bit,
   input  logic [DATA_W-1:0] src1,
   input  logic [DATA_W-1:0] src2,
   output logic [DATA_W-1:0] add_a,
   output logic [DATA_W-1:0] add_b
);

   logic bcast_en;

   assign bcast_en = (enc_class_e'(enc_class) == ENC_EVEX) && mem_form && bcast_bit;
   assign add_a    = src1;

   for (genvar n = 0; n < LANES; n++) begin : g_b
      assign add_b[n*LANE_W +: LANE_W] = bcast_en ? src2[LANE_W-1:0]
                                                  : src2[n*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/vlw_round_ctl.sv
`timescale 1ns/1ps
module vlw_round_ctl
   import vlw_pkg::*;
#(
   parameter int LANES     = 8,
   parameter int MIN_LANES = 2,
   parameter int VLEN_W    = 2,
   parameter int RC_W      = 2
) (
   input  logic [1:0]        enc_class,
   input  logic              mem_form,
   input  logic              bcast_bit,
   input  logic [VLEN_W-1:0] vlen,
   input  logic [RC_W-1:0]   rc_field,
   input  logic [RC_W-1:0]   dflt_rnd,
   output logic              ovr_valid,
   output logic [RC_W-1:0]   rnd_mode
);

   localparam int VLEN_TOP = $clog2(LANES / MIN_LANES);

   logic full_len;

   assign full_len  = (vlen >= VLEN_W'(VLEN_TOP));
   assign ovr_valid = (enc_class_e'(enc_class) == ENC_EVEX) && !mem_form && bcast_bit && full_len;
   assign rnd_mode  = ovr_valid ? rc_field : dflt_rnd;

endmodule

// File: rtl/vlw_lane_mux.sv
`timescale 1ns/1ps
module vlw_lane_mux
   import vlw_pkg::*;
#(
   parameter int LANE_W = 64
) (
   input  logic [1:0]        sel,
   input  logic [LANE_W-1:0] result,
   input  logic [LANE_W-1:0] old,
   output logic [LANE_W-1:0] lane_out
);

   always_comb begin
      case (lane_sel_e'(sel))
         LSEL_RESULT: lane_out = result;
         LSEL_OLD:    lane_out = old;
         default:     lane_out = '0;
      endcase
   end

endmodule

// File: rtl/vec_lane_wb.sv
`timescale 1ns/1ps
module vec_lane_wb
   import vlw_pkg::*;
#(
   parameter int LANE_W    = 64,
   parameter int LANES     = 8,
   parameter int MIN_LANES = 2,
   parameter int VLEN_W    = 2,
   parameter int RC_W      = 2,
   localparam int DATA_W   = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        enc_class,
   input  logic [VLEN_W-1:0] vlen,
   input  logic              mem_form,
   input  logic              bcast_bit,
   input  logic              zero_ctl,
   input  logic [LANES-1:0]  mask,
   input  logic [RC_W-1:0]   rc_field,
   input  logic [RC_W-1:0]   dflt_rnd,
   input  logic [DATA_W-1:0] old_dst,
   input  logic [DATA_W-1:0] src1,
   input  logic [DATA_W-1:0] src2,
   input  logic [DATA_W-1:0] lane_result,
   output logic [DATA_W-1:0] add_a,
   output logic [DATA_W-1:0] add_b,
   output logic              rnd_ovr_valid,
   output logic [RC_W-1:0]   rnd_mode,
   output logic              out_valid,
   output logic [DATA_W-1:0] new_dst
);

   localparam int LOW_W = MIN_LANES * LANE_W;

   initial begin
      assert (LANE_W > 0) else $error("LANE_W must be positive");
      assert (MIN_LANES > 0 && (LANES % MIN_LANES) == 0)
         else $error("LANES must be a multiple of MIN_LANES");
      assert (LANES == (MIN_LANES << $clog2(LANES / MIN_LANES)))
         else $error("LANES / MIN_LANES must be a power of two");
      assert ((MIN_LANES << ((1 << VLEN_W) - 1)) >= LANES)
         else $error("VLEN_W too narrow to reach full length");
      assert (RC_W >= 2) else $error("RC_W must hold four rounding modes");
   end

   logic [LANES-1:0]       active;
   logic [LANES-1:0][1:0]  lane_sel;
   logic [DATA_W-1:0]      nxt_dst;

   vlw_operand_sel #(.LANE_W(LANE_W), .LANES(LANES)) u_opsel (
      .enc_class (enc_class),
      .mem_form  (mem_form),
      .bcast_bit (bcast_bit),
      .src1      (src1),
      .src2      (src2),
      .add_a     (add_a),
      .add_b     (add_b)
   );

   vlw_round_ctl #(.LANES(LANES), .MIN_LANES(MIN_LANES), .VLEN_W(VLEN_W), .RC_W(RC_W)) u_rnd (
      .enc_class (enc_class),
      .mem_form  (mem_form),
      .bcast_bit (bcast_bit),
      .vlen      (vlen),
      .rc_field  (rc_field),
      .dflt_rnd  (dflt_rnd),
      .ovr_valid (rnd_ovr_valid),
      .rnd_mode  (rnd_mode)
   );

   vlw_lane_ctl #(.LANES(LANES), .MIN_LANES(MIN_LANES), .VLEN_W(VLEN_W)) u_ctl (
      .enc_class (enc_class),
      .vlen      (vlen),
      .zero_ctl  (zero_ctl),
      .mask      (mask),
      .active    (active),
      .lane_sel  (lane_sel)
   );

   for (genvar n = 0; n < LANES; n++) begin : g_mux
      vlw_lane_mux #(.LANE_W(LANE_W)) u_mux (
         .sel      (lane_sel[n]),
         .result   (lane_result[n*LANE_W +: LANE_W]),
         .old      (old_dst[n*LANE_W +: LANE_W]),
         .lane_out (nxt_dst[n*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         new_dst   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) new_dst <= nxt_dst;
      end
   end

   // R1: capture timing
   p_valid_pipe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && $past(rst_n)) |=> $stable(new_dst));

   // R2: legacy keeps upper lanes
   p_legacy_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enc_class == ENC_LEGACY) |=>
         new_dst[DATA_W-1:LOW_W] == $past(old_dst[DATA_W-1:LOW_W]));

   // R3: VEX clears lanes past the shortest length
   p_vex_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enc_class == ENC_VEX && vlen == '0) |=> new_dst[DATA_W-1:LOW_W] == '0);

   // R7: EVEX clears lanes past the active length whatever the mask
   p_evex_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enc_class == ENC_EVEX && vlen == '0) |=> new_dst[DATA_W-1:LOW_W] == '0);

   // R6: merge and zero behaviour on lane 0
   p_evex_merge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enc_class == ENC_EVEX && !mask[0] && !zero_ctl) |=>
         new_dst[LANE_W-1:0] == $past(old_dst[LANE_W-1:0]));
   p_evex_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enc_class == ENC_EVEX && !mask[0] && zero_ctl) |=>
         new_dst[LANE_W-1:0] == '0);

   // R5: set mask bit takes the result on lane 0
   p_evex_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enc_class == ENC_EVEX && mask[0]) |=>
         new_dst[LANE_W-1:0] == $past(lane_result[LANE_W-1:0]));

   // R8: broadcast reaches the top lane
   p_bcast_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_class == ENC_EVEX && mem_form && bcast_bit) |->
         add_b[DATA_W-1 -: LANE_W] == src2[LANE_W-1:0]);

   // R9: override only for the register form at full length
   p_rnd_form_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_ovr_valid |-> (enc_class == ENC_EVEX && !mem_form && bcast_bit && active[LANES-1]));
   p_rnd_dflt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rnd_ovr_valid |-> rnd_mode == dflt_rnd);

endmodule

// File: tb/vec_lane_wb_bench.sv
`timescale 1ns/1ps
module vec_lane_wb_bench;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   enc_class = '0;
   logic [1:0]   vlen = '0;
   logic         mem_form = 1'b0;
   logic         bcast_bit = 1'b0;
   logic         zero_ctl = 1'b0;
   logic [7:0]   mask = '0;
   logic [1:0]   rc_field = '0;
   logic [1:0]   dflt_rnd = '0;
   logic [511:0] old_dst = '0, src1 = '0, src2 = '0, lane_result = '0;
   logic [511:0] add_a, add_b, new_dst;
   logic         rnd_ovr_valid, out_valid;
   logic [1:0]   rnd_mode;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vec_lane_wb u_vec_lane_wb (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enc_class(enc_class),
      .vlen(vlen), .mem_form(mem_form), .bcast_bit(bcast_bit), .zero_ctl(zero_ctl),
      .mask(mask), .rc_field(rc_field), .dflt_rnd(dflt_rnd), .old_dst(old_dst),
      .src1(src1), .src2(src2), .lane_result(lane_result), .add_a(add_a),
      .add_b(add_b), .rnd_ovr_valid(rnd_ovr_valid), .rnd_mode(rnd_mode),
      .out_valid(out_valid), .new_dst(new_dst)
   );

   // vector: [14:13] class, [12:11] vlen, [10] mem, [9] bcast, [8] zero, [7:0] mask
   localparam int NV = 15;
   localparam logic [14:0] VEC [NV] = '{
      {2'd0, 2'd2, 1'b1, 1'b1, 1'b1, 8'h00},  // R2 legacy ignores all controls
      {2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'hFF},  // R2
      {2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00},  // R3 two lanes
      {2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 8'h00},  // R3 R4 four lanes
      {2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 8'h5A},  // R3 R4 eight lanes
      {2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 8'h00},  // R4 code 3
      {2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 8'hA5},  // R5 R6 merge
      {2'd2, 2'd2, 1'b0, 1'b0, 1'b1, 8'hA5},  // R5 R6 zero
      {2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 8'hFF},  // R7 tail
      {2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 8'hFC},  // R6 R7
      {2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 8'h0F},  // R8 broadcast
      {2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 8'hFF},  // R9 override
      {2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 8'h33},  // R9 no override below full length
      {2'd1, 2'd2, 1'b1, 1'b1, 1'b0, 8'h00},  // R8 no broadcast outside EVEX
      {2'd3, 2'd1, 1'b1, 1'b1, 1'b1, 8'h00}   // R3 class 3
   };

   function automatic logic [511:0] pat(logic [15:0] tag, int i);
      logic [511:0] v;
      for (int n = 0; n < 8; n++)
         v[n*64 +: 64] = {tag, 8'(i), 8'(n), 32'h1234_5678 ^ 32'(i * 977 + n * 131)};
      return v;
   endfunction

   function automatic logic [511:0] exp_dst(logic [1:0] enc, logic [1:0] vl, logic z,
                                            logic [7:0] m, logic [511:0] od, logic [511:0] rs);
      logic [511:0] e;
      int kl;
      kl = (vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
      for (int n = 0; n < 8; n++) begin
         if (enc == 2'd0)      e[n*64 +: 64] = (n < 2) ? rs[n*64 +: 64] : od[n*64 +: 64];
         else if (enc == 2'd2) e[n*64 +: 64] = (n >= kl) ? 64'h0 : m[n] ? rs[n*64 +: 64]
                                              : z ? 64'h0 : od[n*64 +: 64];
         else                  e[n*64 +: 64] = (n < kl) ? rs[n*64 +: 64] : 64'h0;
      end
      return e;
   endfunction

   task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic run_vec(int i, logic [14:0] v);
      logic [511:0] e, eb;
      logic         eo;
      string        tg;
      @(negedge clk);
      enc_class = v[14:13]; vlen = v[12:11]; mem_form = v[10]; bcast_bit = v[9];
      zero_ctl = v[8]; mask = v[7:0];
      rc_field = 2'(i); dflt_rnd = ~2'(i);
      old_dst = pat(16'h0D0D, i); src1 = pat(16'h5A11, i);
      src2 = pat(16'h5B22, i); lane_result = pat(16'hAE55, i);
      in_valid = 1'b1;
      tg = (v[14:13] == 2'd0) ? "R2" : (v[14:13] == 2'd2) ? "R5 R6 R7" : "R3 R4";
      e = exp_dst(v[14:13], v[12:11], v[8], v[7:0], old_dst, lane_result);
      eb = src2;
      if (v[14:13] == 2'd2 && v[10] && v[9])
         for (int n = 0; n < 8; n++) eb[n*64 +: 64] = src2[63:0];
      eo = (v[14:13] == 2'd2) && !v[10] && v[9] && (v[12:11] >= 2'd2);
      #1;
      chk("R8 add_a", add_a, src1);
      chk("R8 add_b", add_b, eb);
      chk("R9 ovr_valid", 512'(rnd_ovr_valid), 512'(eo));
      chk("R9 rnd_mode", 512'(rnd_mode), 512'(eo ? rc_field : dflt_rnd));
      @(negedge clk);
      in_valid = 1'b0;
      chk("R1 out_valid high", 512'(out_valid), 512'd1);
      chk(tg, new_dst, e);
      old_dst = ~old_dst; lane_result = ~lane_result; mask = ~mask;
      @(negedge clk);
      chk("R1 out_valid low", 512'(out_valid), 512'd0);
      chk("R1 hold", new_dst, e);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL R1 watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      in_valid = 1'b1;
      lane_result = pat(16'hFFFF, 99);
      repeat (3) @(negedge clk);
      chk("R1 reset out_valid", 512'(out_valid), 512'd0);
      chk("R1 reset new_dst", new_dst, 512'd0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", new_dst, 512'd0);

      for (int i = 0; i < NV; i++) run_vec(i, VEC[i]);

      // R2: legacy with every control toggled gives the same writeback
      run_vec(40, {2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 8'h00});
      run_vec(40, {2'd0, 2'd3, 1'b1, 1'b1, 1'b1, 8'hFF});
      // R7: mask bits only above length set, zero off: lanes 0..1 merge, rest zero
      run_vec(41, {2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 8'hFC});
      // R5: every lane masked in at full length
      run_vec(42, {2'd2, 2'd3, 1'b0, 1'b0, 1'b1, 8'hFF});
      // R8 R9: broadcast memory form never raises the override
      run_vec(43, {2'd2, 2'd3, 1'b1, 1'b1, 1'b1, 8'h81});

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule